// File: doc/BRIEF.md
# Split Read Completer

This block serves as the target of a bus that supports deferred reads. A memory write that reaches it is taken at once into a small local memory. A read is not answered in the same transaction. The block ends the read with a split answer and stores the requester ID, tag, word-aligned start address and remaining byte count in a four-slot pending table. The requester ID and the tag together form the sequence identifier.

Each table slot waits a fixed latency until its local data is ready. When the bus grant is present, the block starts its own completion transactions back to the requester. Each completion is a header cycle that carries the sequence identifier, the address and the byte count of that completion. One 32-bit data beat per cycle follows the header, with no gaps between beats. A completion stops at the end of the sequence or at the next 128-byte address boundary, whichever comes first. The remaining data is carried by further completions in rising address order until the whole count has been returned. After that, the slot is freed.

Each request gets a 2-bit answer in the cycle after it is sampled: 0 accepted, 1 split, 2 retry, 3 sequence error.

Top module: `split_completer`

## Requirements
- R1: A write request (reqIsWrite=1) with a sequence identifier that is not pending is answered with kind 0 one cycle after it is sampled. It stores reqData at word index reqAddr[9:2] and never takes a table slot, even when the table is full.
- R2: A read with a byte count of at least 4, with a free slot and a sequence identifier that is not pending, is answered with kind 1. It is recorded with address and count rounded down to a multiple of 4.
- R3: A read that arrives while all four slots are pending is answered with kind 2, and nothing is recorded.
- R4: A request of either type whose requester ID and tag match a pending slot is answered with kind 3 and has no effect. A write is not stored and no slot is taken.
- R5: A read whose byte count is below 4 is answered with kind 3 and records nothing.
- R6: A completion header (cplStart) appears only when cplGnt was high in the previous cycle. The first completion of a read comes no earlier than 8 cycles after the split answer.
- R7: A completion header carries the requester ID and tag of its slot. The completions of one read have contiguous, rising addresses that start at the recorded address.
- R8: The byte count of each completion equals the smaller of the remaining count and the distance to the next 128-byte boundary, so that no completion crosses such a boundary.
- R9: After each header, cplByteCount/4 beats follow back to back, starting the next cycle. Each beat carries the memory word at the next address, and cplLast marks the final beat. No beat appears outside a completion.
- R10: A slot is released at the clock edge that ends the header of its final completion. A request sampled at that same edge still sees the slot as pending, and a request sampled one cycle later can use it.
- R11: After reset, respValid, cplStart and cplDataValid are low.
- R12: Every split read is eventually returned in full once the grant is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqIsWrite | input | 1 | 1 = memory write, 0 = read |
| reqAddr | input | 16 | Byte address of the request |
| reqByteCount | input | 13 | Byte count of the request |
| reqRequesterId | input | 16 | Requester identity |
| reqTag | input | 5 | Requester sequence tag |
| reqData | input | 32 | Write data word |
| respValid | output | 1 | Answer to the request of the previous cycle |
| respKind | output | 2 | 0 accept, 1 split, 2 retry, 3 sequence error |
| cplGnt | input | 1 | Bus grant for completions |
| cplStart | output | 1 | Completion header cycle |
| cplRequesterId | output | 16 | Header requester ID |
| cplTag | output | 5 | Header tag |
| cplAddr | output | 16 | Header start address |
| cplByteCount | output | 13 | Header byte count of this completion |
| cplDataValid | output | 1 | Completion data beat |
| cplData | output | 32 | Beat data |
| cplLast | output | 1 | Final beat of this completion |

## Verification
The critical overlap is a new request sampled at the same edge that frees a slot, which is the edge closing the header of a final completion. The bench fills the table with single-beat reads and raises the grant. It watches for each header and sends a request in that same cycle. It expects a retry when the table is full, a sequence error when the request reuses the identifier of the completing slot, and a split answer for a request sent one cycle later. Random traffic with a toggling grant and a small identifier pool also causes allocations, duplicate hits and completion launches to land in the same cycles. An independent table model in the bench judges each of these cases.

// File: rtl/stc_pkg.sv
package stc_pkg;

  typedef enum logic [1:0] {
    RESP_ACCEPT = 2'd0,
    RESP_SPLIT  = 2'd1,
    RESP_RETRY  = 2'd2,
    RESP_SEQERR = 2'd3
  } respKind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2
  } cplState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      memWr;
    logic      respLoad;
    respKind_e respKind;
    logic      hdrLoad;
    logic      beatStep;
  } strobes_t;

endpackage

// File: rtl/stc_ctrl.sv
module stc_ctrl
  import stc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BC_W        = 13,
  parameter int RID_W       = 16,
  parameter int TAG_W       = 5,
  parameter int DATA_W      = 32,
  parameter int ENTRIES     = 4,
  parameter int BOUND_BYTES = 128,
  parameter int DATA_LAT    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BC_W-1:0]   reqByteCount,
  input  logic [RID_W-1:0]  reqRequesterId,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic              cplGnt,
  output strobes_t          stb,
  output logic [RID_W-1:0]  selRid,
  output logic [TAG_W-1:0]  selTag,
  output logic [ADDR_W-1:0] selAddr,
  output logic [BC_W-1:0]   selChunk,
  output logic              inHdr,
  output logic              inData,
  output logic              lastBeat
);

  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int LAT_W     = $clog2(DATA_LAT + 1);
  localparam int BOUND_LOG = $clog2(BOUND_BYTES);
  localparam int BEAT_LOG  = $clog2(DATA_W / 8);

  logic              entValid [ENTRIES];
  logic [RID_W-1:0]  entRid   [ENTRIES];
  logic [TAG_W-1:0]  entTag   [ENTRIES];
  logic [ADDR_W-1:0] entAddr  [ENTRIES];
  logic [BC_W-1:0]   entRem   [ENTRIES];
  logic [LAT_W-1:0]  entWait  [ENTRIES];

  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] eligVec;
  logic [IDX_W-1:0]   freeIdx, eligIdx, curIdx;
  logic               anyFree, anyElig, alloc;
  logic [BC_W-1:0]    toBound, chunk, curChunk, beatsLeft;
  cplState_e          state;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign hitVec[i]  = entValid[i] && (entRid[i] == reqRequesterId) && (entTag[i] == reqTag);
    assign eligVec[i] = entValid[i] && (entWait[i] == '0);
  end

  // lowest-index pickers
  always_comb begin
    freeIdx = '0;
    anyFree = 1'b0;
    eligIdx = '0;
    anyElig = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!entValid[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
      if (eligVec[i]) begin
        eligIdx = IDX_W'(i);
        anyElig = 1'b1;
      end
    end
  end

  // completion size: stop at end of sequence or next boundary
  always_comb begin
    toBound  = BC_W'(BOUND_BYTES) - BC_W'(entAddr[eligIdx][BOUND_LOG-1:0]);
    chunk    = (entRem[eligIdx] < toBound) ? entRem[eligIdx] : toBound;
    selRid   = entRid[eligIdx];
    selTag   = entTag[eligIdx];
    selAddr  = entAddr[eligIdx];
    selChunk = chunk;
  end

  // request decision
  always_comb begin
    stb          = '0;
    stb.respKind = RESP_ACCEPT;
    alloc        = 1'b0;
    if (reqValid) begin
      stb.respLoad = 1'b1;
      if (|hitVec) begin
        stb.respKind = RESP_SEQERR;
      end else if (reqIsWrite) begin
        stb.memWr = 1'b1;
      end else if (reqByteCount[BC_W-1:BEAT_LOG] == '0) begin
        stb.respKind = RESP_SEQERR;
      end else if (!anyFree) begin
        stb.respKind = RESP_RETRY;
      end else begin
        stb.respKind = RESP_SPLIT;
        alloc        = 1'b1;
      end
    end
    stb.hdrLoad  = (state == ST_IDLE) && cplGnt && anyElig;
    stb.beatStep = (state == ST_DATA);
  end

  assign inHdr    = (state == ST_HDR);
  assign inData   = (state == ST_DATA);
  assign lastBeat = (state == ST_DATA) && (beatsLeft == BC_W'(1));

  // completion sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      curIdx    <= '0;
      curChunk  <= '0;
      beatsLeft <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (stb.hdrLoad) begin
            curIdx   <= eligIdx;
            curChunk <= chunk;
            state    <= ST_HDR;
          end
        end
        ST_HDR: begin
          beatsLeft <= curChunk >> BEAT_LOG;
          state     <= ST_DATA;
        end
        ST_DATA: begin
          beatsLeft <= beatsLeft - BC_W'(1);
          if (beatsLeft == BC_W'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // pending table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        entValid[i] <= 1'b0;
        entRid[i]   <= '0;
        entTag[i]   <= '0;
        entAddr[i]  <= '0;
        entRem[i]   <= '0;
        entWait[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (entValid[i] && (entWait[i] != '0)) entWait[i] <= entWait[i] - LAT_W'(1);
      end
      if (alloc) begin
        entValid[freeIdx] <= 1'b1;
        entRid[freeIdx]   <= reqRequesterId;
        entTag[freeIdx]   <= reqTag;
        entAddr[freeIdx]  <= {reqAddr[ADDR_W-1:BEAT_LOG], {BEAT_LOG{1'b0}}};
        entRem[freeIdx]   <= {reqByteCount[BC_W-1:BEAT_LOG], {BEAT_LOG{1'b0}}};
        entWait[freeIdx]  <= LAT_W'(DATA_LAT);
      end
      if (state == ST_HDR) begin
        entAddr[curIdx] <= entAddr[curIdx] + ADDR_W'(curChunk);
        entRem[curIdx]  <= entRem[curIdx] - curChunk;
        if (entRem[curIdx] == curChunk) entValid[curIdx] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/stc_datapath.sv
module stc_datapath
  import stc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BC_W      = 13,
  parameter int RID_W     = 16,
  parameter int TAG_W     = 5,
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [RID_W-1:0]  selRid,
  input  logic [TAG_W-1:0]  selTag,
  input  logic [ADDR_W-1:0] selAddr,
  input  logic [BC_W-1:0]   selChunk,
  output logic              respValid,
  output logic [1:0]        respKind,
  output logic [RID_W-1:0]  hdrRid,
  output logic [TAG_W-1:0]  hdrTag,
  output logic [ADDR_W-1:0] hdrAddr,
  output logic [BC_W-1:0]   hdrCount,
  output logic [DATA_W-1:0] beatData
);

  localparam int MEM_AW     = $clog2(MEM_WORDS);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int BEAT_LOG   = $clog2(BEAT_BYTES);

  logic [DATA_W-1:0] mem [MEM_WORDS];
  logic [ADDR_W-1:0] beatAddr;
  respKind_e         respKindQ;

  always_ff @(posedge clk) begin
    if (stb.memWr) mem[reqAddr[BEAT_LOG +: MEM_AW]] <= reqData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respKindQ <= RESP_ACCEPT;
    end else begin
      respValid <= stb.respLoad;
      respKindQ <= stb.respKind;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrRid   <= '0;
      hdrTag   <= '0;
      hdrAddr  <= '0;
      hdrCount <= '0;
      beatAddr <= '0;
    end else if (stb.hdrLoad) begin
      hdrRid   <= selRid;
      hdrTag   <= selTag;
      hdrAddr  <= selAddr;
      hdrCount <= selChunk;
      beatAddr <= selAddr;
    end else if (stb.beatStep) begin
      beatAddr <= beatAddr + ADDR_W'(BEAT_BYTES);
    end
  end

  assign respKind = respKindQ;
  assign beatData = mem[beatAddr[BEAT_LOG +: MEM_AW]];

endmodule

// File: rtl/split_completer.sv
module split_completer
  import stc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BC_W        = 13,
  parameter int RID_W       = 16,
  parameter int TAG_W       = 5,
  parameter int DATA_W      = 32,
  parameter int ENTRIES     = 4,
  parameter int BOUND_BYTES = 128,
  parameter int DATA_LAT    = 8,
  parameter int MEM_WORDS   = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BC_W-1:0]   reqByteCount,
  input  logic [RID_W-1:0]  reqRequesterId,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [DATA_W-1:0] reqData,
  output logic              respValid,
  output logic [1:0]        respKind,
  input  logic              cplGnt,
  output logic              cplStart,
  output logic [RID_W-1:0]  cplRequesterId,
  output logic [TAG_W-1:0]  cplTag,
  output logic [ADDR_W-1:0] cplAddr,
  output logic [BC_W-1:0]   cplByteCount,
  output logic              cplDataValid,
  output logic [DATA_W-1:0] cplData,
  output logic              cplLast
);

  strobes_t          stb;
  logic [RID_W-1:0]  selRid;
  logic [TAG_W-1:0]  selTag;
  logic [ADDR_W-1:0] selAddr;
  logic [BC_W-1:0]   selChunk;
  logic              inHdr, inData, lastBeat;

  stc_ctrl #(
    .ADDR_W(ADDR_W), .BC_W(BC_W), .RID_W(RID_W), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .ENTRIES(ENTRIES), .BOUND_BYTES(BOUND_BYTES), .DATA_LAT(DATA_LAT)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqIsWrite(reqIsWrite), .reqAddr(reqAddr),
    .reqByteCount(reqByteCount), .reqRequesterId(reqRequesterId), .reqTag(reqTag),
    .cplGnt(cplGnt), .stb(stb),
    .selRid(selRid), .selTag(selTag), .selAddr(selAddr), .selChunk(selChunk),
    .inHdr(inHdr), .inData(inData), .lastBeat(lastBeat)
  );

  stc_datapath #(
    .ADDR_W(ADDR_W), .BC_W(BC_W), .RID_W(RID_W), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .MEM_WORDS(MEM_WORDS)
  ) uPath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqAddr(reqAddr), .reqData(reqData),
    .selRid(selRid), .selTag(selTag), .selAddr(selAddr), .selChunk(selChunk),
    .respValid(respValid), .respKind(respKind),
    .hdrRid(cplRequesterId), .hdrTag(cplTag), .hdrAddr(cplAddr), .hdrCount(cplByteCount),
    .beatData(cplData)
  );

  assign cplStart     = inHdr;
  assign cplDataValid = inData;
  assign cplLast      = lastBeat;

endmodule

// File: rtl/split_completer_chk.sv
module split_completer_chk #(
  parameter int ADDR_W      = 16,
  parameter int BC_W        = 13,
  parameter int BOUND_BYTES = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              respValid,
  input logic              cplGnt,
  input logic              cplStart,
  input logic [ADDR_W-1:0] cplAddr,
  input logic [BC_W-1:0]   cplByteCount,
  input logic              cplDataValid,
  input logic              cplLast
);

  localparam int BOUND_LOG = $clog2(BOUND_BYTES);

  // R1
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(reqValid));

  // R6
  hdr_needs_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplStart |-> $past(cplGnt));

  // R8
  hdr_in_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplStart |-> ((cplByteCount != '0) &&
                  ((int'(cplAddr[BOUND_LOG-1:0]) + int'(cplByteCount)) <= BOUND_BYTES)));

  // R9
  hdr_then_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplStart |=> cplDataValid);

  // R9
  beats_contig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cplDataValid && !cplLast) |=> cplDataValid);

  // R9
  hdr_beat_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cplStart && cplDataValid));

  // R9
  last_in_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplLast |-> cplDataValid);

endmodule

bind split_completer split_completer_chk #(
  .ADDR_W(ADDR_W), .BC_W(BC_W), .BOUND_BYTES(BOUND_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .respValid(respValid),
  .cplGnt(cplGnt), .cplStart(cplStart), .cplAddr(cplAddr),
  .cplByteCount(cplByteCount), .cplDataValid(cplDataValid), .cplLast(cplLast)
);

// File: tb/sim_split_completer.sv
module sim_split_completer;

  localparam int CLK_PERIOD = 10;
  localparam int NSLOT      = 4;
  localparam int LAT        = 8;
  localparam int NWORDS     = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqIsWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [12:0] reqByteCount = '0;
  logic [15:0] reqRequesterId = '0;
  logic [4:0]  reqTag = '0;
  logic [31:0] reqData = '0;
  logic        respValid;
  logic [1:0]  respKind;
  logic        cplGnt = 1'b0;
  logic        cplStart;
  logic [15:0] cplRequesterId;
  logic [4:0]  cplTag;
  logic [15:0] cplAddr;
  logic [12:0] cplByteCount;
  logic        cplDataValid;
  logic [31:0] cplData;
  logic        cplLast;

  split_completer u0 (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int gntMode = 0;
  int hdrSeen = 0;
  logic gntQ = 1'b0;

  // bench model
  logic [31:0] memModel [NWORDS];
  bit mValid [NSLOT];
  bit mFree  [NSLOT];
  bit mFirst [NSLOT];
  int mRid [NSLOT];
  int mTag [NSLOT];
  int mAddr [NSLOT];
  int mRem [NSLOT];
  int mAlloc [NSLOT];
  int bLeft = 0;
  int bAddr = 0;

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    gntQ <= cplGnt;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R12 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      finishRun();
    end
  end

  always @(negedge clk) begin
    #1;
    case (gntMode)
      0: cplGnt = 1'b0;
      1: cplGnt = 1'b1;
      default: cplGnt = ($urandom % 3) != 0;
    endcase
  end

  function automatic int chunkOf(input int addr, input int rem);
    int tb;
    tb = 128 - (addr % 128);
    return (rem < tb) ? rem : tb;
  endfunction

  function automatic int expKind(input bit isWr, input int cnt, input int rid, input int tag);
    bit full;
    full = 1'b1;
    for (int i = 0; i < NSLOT; i++) begin
      if (mValid[i] && mRid[i] == rid && mTag[i] == tag) return 3;
      if (!mValid[i]) full = 1'b0;
    end
    if (isWr) return 0;
    if (cnt < 4) return 3;
    if (full) return 2;
    return 1;
  endfunction

  function automatic bit modelEmpty();
    for (int i = 0; i < NSLOT; i++) if (mValid[i]) return 1'b0;
    return (bLeft == 0);
  endfunction

  // called at negedge+1, returns at next negedge+1
  task automatic issue(input bit isWr, input int addr, input int cnt, input int rid,
                       input int tag, input logic [31:0] data, input string rq, output int got);
    int exp;
    int slot;
    exp = expKind(isWr, cnt, rid, tag);
    reqValid = 1'b1;
    reqIsWrite = isWr;
    reqAddr = 16'(addr);
    reqByteCount = 13'(cnt);
    reqRequesterId = 16'(rid);
    reqTag = 5'(tag);
    reqData = data;
    @(negedge clk);
    #1;
    reqValid = 1'b0;
    got = respValid ? int'(respKind) : -1;
    check(got == exp, rq, got, exp);
    if (exp == 0 && isWr) memModel[(addr >> 2) % NWORDS] = data;
    if (exp == 1) begin
      slot = -1;
      for (int i = 0; i < NSLOT; i++) if (!mValid[i] && slot < 0) slot = i;
      if (slot >= 0) begin
        mValid[slot] = 1'b1;
        mFree[slot] = 1'b0;
        mFirst[slot] = 1'b1;
        mRid[slot] = rid;
        mTag[slot] = tag;
        mAddr[slot] = addr & ~3;
        mRem[slot] = cnt & ~3;
        mAlloc[slot] = cyc;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic drain(input string rq);
    int n;
    n = 0;
    while (!modelEmpty() && n < 20000) begin
      @(negedge clk);
      n++;
    end
    #1;
    check(modelEmpty(), rq, n, 0);
  endtask

  // completion monitor
  always @(negedge clk) begin
    if (rstN) begin
      int k;
      int ch;
      for (int i = 0; i < NSLOT; i++) begin
        if (mFree[i]) begin
          mValid[i] = 1'b0;
          mFree[i] = 1'b0;
        end
      end
      if (bLeft > 0) begin
        check(cplDataValid == 1'b1, "R9 beat missing", cplDataValid, 1);
        check(cplData == memModel[(bAddr >> 2) % NWORDS], "R9 beat data", cplData,
              memModel[(bAddr >> 2) % NWORDS]);
        check(cplLast == (bLeft == 1), "R9 last flag", cplLast, bLeft == 1);
        bLeft--;
        bAddr += 4;
      end else if (cplDataValid) begin
        check(1'b0, "R9 stray beat", 1, 0);
      end
      if (cplStart) begin
        hdrSeen++;
        check(gntQ == 1'b1, "R6 header without grant", gntQ, 1);
        k = -1;
        for (int i = 0; i < NSLOT; i++)
          if (mValid[i] && !mFree[i] && mRid[i] == int'(cplRequesterId) && mTag[i] == int'(cplTag)) k = i;
        if (k < 0) begin
          check(1'b0, "R7 header of unknown sequence", {cplRequesterId, 3'b0, cplTag}, 0);
        end else begin
          ch = chunkOf(mAddr[k], mRem[k]);
          check(int'(cplAddr) == mAddr[k], "R7 completion address", cplAddr, mAddr[k]);
          check(int'(cplByteCount) == ch, "R8 completion byte count", cplByteCount, ch);
          if (mFirst[k]) check(cyc - mAlloc[k] >= LAT, "R6 early first completion", cyc - mAlloc[k], LAT);
          mFirst[k] = 1'b0;
          bAddr = mAddr[k];
          bLeft = ch / 4;
          mAddr[k] += ch;
          mRem[k] -= ch;
          if (mRem[k] <= 0) mFree[k] = 1'b1;
        end
      end
    end
  end

  initial begin
    int got;
    int dummy;
    int op, a, c, t, r;
    dummy = $urandom(32'd90210);
    for (int i = 0; i < NSLOT; i++) begin
      mValid[i] = 1'b0;
      mFree[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R11
    check(respValid == 1'b0, "R11 respValid after reset", respValid, 0);
    check(cplStart == 1'b0, "R11 cplStart after reset", cplStart, 0);
    check(cplDataValid == 1'b0, "R11 cplDataValid after reset", cplDataValid, 0);

    // R1: load the whole memory
    for (int i = 0; i < NWORDS; i++) issue(1, i * 4, 4, 16'h0200, i % 32, $urandom, "R1 fill write", got);

    // directed: boundary split, sequence errors, full table
    issue(0, 16'h070, 40, 16'h0A00, 1, 0, "R2 read split", got);
    check(got == 1, "R2 split kind", got, 1);
    issue(0, 16'h100, 3, 16'h0A00, 9, 0, "R5 short read", got);
    check(got == 3, "R5 short read kind", got, 3);
    issue(0, 16'h080, 8, 16'h0A00, 1, 0, "R4 duplicate read", got);
    check(got == 3, "R4 duplicate read kind", got, 3);
    issue(1, 16'h300, 4, 16'h0A00, 1, 32'hDEAD_BEEF, "R4 duplicate write", got);
    issue(0, 16'h300, 8, 16'h0A00, 2, 0, "R2 read back of dup-write word", got);
    issue(0, 16'h000, 256, 16'h0A00, 3, 0, "R2 read two blocks", got);
    issue(0, 16'h044, 1024, 16'h0A01, 4, 0, "R2 long read", got);
    issue(0, 16'h200, 16, 16'h0A01, 5, 0, "R3 read while full", got);
    check(got == 2, "R3 retry kind", got, 2);
    issue(1, 16'h304, 4, 16'h0A01, 6, 32'h1234_5678, "R1 write while full", got);
    check(got == 0, "R1 accept while full", got, 0);
    idle(30);
    check(hdrSeen == 0, "R6 no completion without grant", hdrSeen, 0);
    gntMode = 1;
    drain("R12 directed drain");

    // R10: request sampled at the edge that frees a slot
    gntMode = 0;
    idle(2);
    for (int i = 0; i < NSLOT; i++) issue(0, 16'h010 + i * 4, 4, 16'h0B00, 8 + i, 0, "R2 small read", got);
    idle(12);
    gntMode = 1;
    do begin @(negedge clk); #1; end while (!cplStart);
    issue(0, 16'h020, 4, 16'h0B00, 12, 0, "R10 read at freeing edge", got);
    check(got == 2, "R10 still full at freeing edge", got, 2);
    issue(0, 16'h020, 4, 16'h0B00, 12, 0, "R10 read after freeing edge", got);
    check(got == 1, "R10 slot reusable next cycle", got, 1);
    do begin @(negedge clk); #1; end while (!cplStart);
    issue(1, 16'h3F0, 4, int'(cplRequesterId), int'(cplTag), 32'hAAAA_5555,
          "R10 same id at freeing edge", got);
    check(got == 3, "R10 id still pending at freeing edge", got, 3);
    drain("R12 drain after overlap");
    issue(0, 16'h3F0, 4, 16'h0B01, 0, 0, "R4 word untouched by rejected write", got);
    drain("R12 drain read back");

    // constrained random traffic with toggling grant
    gntMode = 2;
    for (int n = 0; n < 200; n++) begin
      op = $urandom % 10;
      r = 16'h0100 + ($urandom % 2);
      t = $urandom % 4;
      if (op < 8) begin
        a = ($urandom % 128) * 4;
        c = (($urandom % 16) == 0) ? ($urandom % 4) : (1 + $urandom % 64) * 4;
        issue(0, a, c, r, t, 0, "R2 random read", got);
      end else begin
        a = 768 + ($urandom % 64) * 4;
        issue(1, a, 4, r, t, $urandom, "R1 random write", got);
      end
      idle($urandom % 4);
    end
    gntMode = 1;
    drain("R12 final drain");
    finishRun();
  end

endmodule